// File: doc/BRIEF.md
# PDM Multichannel Edge-Offset Sampler

This block captures one-bit pulse-density microphone streams for up to eight channels. Each serial data line carries two channels: the even channel drives the line while the bit clock is high, the odd channel while it is low. The bit clock and the data lines come in from outside. They are synchronised into the fast system clock, and a counter restarts at every edge of the synchronised bit clock. Each channel has its own 8-bit pointer. The channel's bit is taken in the system-clock cycle where the counter equals that pointer, inside the half period the channel owns. This lets the capture point sit at a chosen distance from the edge, which matters because microphones only settle their outputs some time after the clock edge.

A phase state machine follows the bit clock. It has four states. PH_IDLE is used while the global enable is off. PH_ALIGN waits for the first rising edge so that only whole periods are counted. PH_HIGH covers the even half and PH_LOW the odd half. The transitions are: IDLE→ALIGN when enabled; ALIGN→HIGH on a rising edge; HIGH→LOW on a falling edge; LOW→HIGH on a rising edge; any state→IDLE when the global enable drops. The LOW→HIGH transition closes a period. On that transition the block presents one bit per channel together with a single-cycle valid strobe.

The pointer reset value is computed from two parameters, the system clock rate and the bit clock rate. It is three quarters of the half-period count, and that half-period count is rounded up.

Top module: `pdm_edge_sampler`

## Requirements
- R1: After reset, the control word reads 0, both pointer words read 0x18181818 (pointer 24 for the default 200 MHz system clock and 3.072 MHz bit clock), and smp_bits and smp_valid are 0.
- R2: Register access uses cfg_addr. Address 0 is the control word: bit 31 is the global enable, bits 15:8 are the active-low channel resets and bits 7:0 are the channel enables. Address 1 holds the pointers of channels 0–3. Address 2 holds the pointers of channels 4–7. Channel i sits in byte i mod 4. Every other bit, and address 3, reads as 0.
- R3: Bit 2k of smp_bits is line k sampled during the high half of the bit clock. Bit 2k+1 is line k sampled during the low half.
- R4: The counter restarts at 0 at each synchronised edge. A channel samples its line in the cycle where the counter equals its pointer, so data that changes after that point in the half period is not seen.
- R5: A channel whose pointer is beyond the last count of its half period reports 0 for that period.
- R6: A channel is active only when the global enable, its enable bit and its reset-release bit are all 1. An inactive channel reports 0.
- R7: While the global enable is 0, no valid strobe is produced. After enabling, the first rising edge only aligns the block, and the first strobe follows one full period later.
- R8: smp_valid is a single-cycle pulse, and there is exactly one pulse per bit-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_in | input | 1 | PDM bit clock, asynchronous to clk |
| pdm_din | input | NUM_LINES | Serial PDM data lines, two channels per line |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| smp_bits | output | 2*NUM_LINES | Captured bit per channel for the last period |
| smp_valid | output | 1 | One-cycle strobe when smp_bits is updated |

## Verification
The phase state can go wrong in two ways. If it slips by one half, even and odd channels trade places, and smp_bits shows the swap at the very first strobe after enable. A counter that fails to restart moves every capture point, so directed data that changes a few cycles into a half period shows the error in the next strobe. If a channel's capture state is not cleared while the channel is inactive or between periods, a stale 1 appears in smp_bits one period later. A state machine that leaves its idle state too early shows up as a strobe one period sooner than expected.

// File: rtl/pdm_samp_pkg.sv
package pdm_samp_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ALIGN = 2'd1,
        PH_HIGH  = 2'd2,
        PH_LOW   = 2'd3
    } phase_e;

    localparam int REG_W       = 32;
    localparam int CTRL_ADDR   = 0;
    localparam int PTR_BASE    = 1;
    localparam int GLOB_EN_BIT = 31;
    localparam int RSTN_LSB    = 8;
    localparam int EN_LSB      = 0;
endpackage

// File: rtl/pdm_sig_sync.sv
module pdm_sig_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pdm_samp_regs.sv
module pdm_samp_regs
    import pdm_samp_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int PTR_W   = 8,
    parameter int DEF_PTR = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [1:0]              addr,
    input  logic [REG_W-1:0]        wdata,
    output logic [REG_W-1:0]        rdata,
    output logic                    glob_en,
    output logic [NUM_CH-1:0]       ch_en,
    output logic [NUM_CH-1:0]       ch_rstn,
    output logic [NUM_CH*PTR_W-1:0] ptr_flat
);
    localparam int PER_WORD = REG_W / PTR_W;

    logic             glob_q;
    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] rstn_q;
    logic [PTR_W-1:0]  ptr_q [NUM_CH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glob_q <= 1'b0;
            en_q   <= '0;
            rstn_q <= '0;
            for (int i = 0; i < NUM_CH; i++) ptr_q[i] <= PTR_W'(DEF_PTR);
        end else if (we) begin
            if (int'(addr) == CTRL_ADDR) begin
                glob_q <= wdata[GLOB_EN_BIT];
                en_q   <= wdata[EN_LSB +: NUM_CH];
                rstn_q <= wdata[RSTN_LSB +: NUM_CH];
            end
            for (int i = 0; i < NUM_CH; i++) begin
                if (int'(addr) == PTR_BASE + i / PER_WORD)
                    ptr_q[i] <= wdata[(i % PER_WORD)*PTR_W +: PTR_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(addr) == CTRL_ADDR) begin
            rdata[GLOB_EN_BIT]        = glob_q;
            rdata[EN_LSB +: NUM_CH]   = en_q;
            rdata[RSTN_LSB +: NUM_CH] = rstn_q;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (int'(addr) == PTR_BASE + i / PER_WORD)
                rdata[(i % PER_WORD)*PTR_W +: PTR_W] = ptr_q[i];
        end
    end

    assign glob_en = glob_q;
    assign ch_en   = en_q;
    assign ch_rstn = rstn_q;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ptr
            assign ptr_flat[g*PTR_W +: PTR_W] = ptr_q[g];
        end
    endgenerate
endmodule

// File: rtl/pdm_phase_fsm.sv
module pdm_phase_fsm
    import pdm_samp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glob_en,
    input  logic             rise,
    input  logic             fall,
    output phase_e           state,
    output logic [CNT_W-1:0] cnt,
    output logic             period_done
);
    phase_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:  if (glob_en) state_d = PH_ALIGN;
            PH_ALIGN: if (rise)    state_d = PH_HIGH;
            PH_HIGH:  if (fall)    state_d = PH_LOW;
            PH_LOW:   if (rise)    state_d = PH_HIGH;
            default:               state_d = PH_IDLE;
        endcase
        if (!glob_en) state_d = PH_IDLE;
    end

    always_comb begin
        state       = state_q;
        period_done = glob_en && (state_q == PH_LOW) && rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (rise || fall)  cnt <= '0;
        else if (cnt != '1)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pdm_chan_cap.sv
module pdm_chan_cap
    import pdm_samp_pkg::*;
#(
    parameter int PTR_W    = 8,
    parameter bit ODD_SLOT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  phase_e           state,
    input  logic [PTR_W-1:0] cnt,
    input  logic [PTR_W-1:0] ptr,
    input  logic             din,
    input  logic             clear,
    output logic             bit_next,
    output logic             bit_q
);
    localparam phase_e OWN_PHASE = ODD_SLOT ? PH_LOW : PH_HIGH;

    logic hit;

    assign hit      = active && (state == OWN_PHASE) && (cnt == ptr);
    assign bit_next = hit ? din : bit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                bit_q <= 1'b0;
        else if (!active || clear) bit_q <= 1'b0;
        else                       bit_q <= bit_next;
    end
endmodule

// File: rtl/pdm_edge_sampler.sv
module pdm_edge_sampler
    import pdm_samp_pkg::*;
#(
    parameter int NUM_LINES   = 4,
    parameter int PTR_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SYS_CLK_HZ  = 200_000_000,
    parameter int BIT_CLK_HZ  = 3_072_000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bclk_in,
    input  logic [NUM_LINES-1:0]   pdm_din,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_addr,
    input  logic [31:0]            cfg_wdata,
    output logic [31:0]            cfg_rdata,
    output logic [2*NUM_LINES-1:0] smp_bits,
    output logic                   smp_valid
);
    localparam int NUM_CH   = 2 * NUM_LINES;
    localparam int HALF_MAX = (SYS_CLK_HZ + 2*BIT_CLK_HZ - 1) / (2*BIT_CLK_HZ);
    localparam int DEF_PTR  = HALF_MAX * 3 / 4;

    logic [NUM_LINES:0]     sync_q;
    logic                   lvl, lvl_d, rise, fall;
    logic [NUM_LINES-1:0]   lines;
    logic                   glob_en;
    logic [NUM_CH-1:0]      ch_en, ch_rstn, active, bit_next, bit_q;
    logic [NUM_CH*PTR_W-1:0] ptr_flat;
    phase_e                 state;
    logic [PTR_W-1:0]       cnt;
    logic                   period_done;

    pdm_sig_sync #(.W(NUM_LINES+1), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({bclk_in, pdm_din}), .q(sync_q)
    );

    assign lvl   = sync_q[NUM_LINES];
    assign lines = sync_q[NUM_LINES-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    assign rise = lvl & ~lvl_d;
    assign fall = ~lvl & lvl_d;

    pdm_samp_regs #(.NUM_CH(NUM_CH), .PTR_W(PTR_W), .DEF_PTR(DEF_PTR)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .glob_en(glob_en),
        .ch_en(ch_en), .ch_rstn(ch_rstn), .ptr_flat(ptr_flat)
    );

    pdm_phase_fsm #(.CNT_W(PTR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .rise(rise), .fall(fall),
        .state(state), .cnt(cnt), .period_done(period_done)
    );

    assign active = {NUM_CH{glob_en}} & ch_en & ch_rstn;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            pdm_chan_cap #(.PTR_W(PTR_W), .ODD_SLOT(g % 2 == 1)) u_cap (
                .clk(clk), .rst_n(rst_n), .active(active[g]), .state(state),
                .cnt(cnt), .ptr(ptr_flat[g*PTR_W +: PTR_W]), .din(lines[g/2]),
                .clear(period_done), .bit_next(bit_next[g]), .bit_q(bit_q[g])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_bits  <= '0;
            smp_valid <= 1'b0;
        end else begin
            smp_valid <= period_done;
            if (period_done) smp_bits <= bit_next & active;
        end
    end
endmodule

// File: rtl/pdm_edge_sampler_chk.sv
module pdm_edge_sampler_chk
    import pdm_samp_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              glob_en,
    input logic [NUM_CH-1:0] active,
    input logic              smp_valid,
    input logic [NUM_CH-1:0] smp_bits,
    input phase_e            state,
    input logic              lvl,
    input logic              fall
);
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);                                      // R8

    AST_INACTIVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> ((smp_bits & ~$past(active)) == '0));              // R6

    AST_NO_STROBE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!glob_en) |-> !smp_valid);                                // R7

    AST_NO_SKIP_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_HIGH) |-> ($past(state) != PH_IDLE));              // R7

    AST_HIGH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_HIGH && !fall) |-> lvl);                           // R3
endmodule

bind pdm_edge_sampler pdm_edge_sampler_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .active(active),
    .smp_valid(smp_valid), .smp_bits(smp_bits), .state(state),
    .lvl(lvl), .fall(fall)
);

// File: tb/pdm_edge_sampler_tb_top.sv
`timescale 1ns/1ps
module pdm_edge_sampler_tb_top;
    localparam int NL   = 4;
    localparam int NC   = 8;
    localparam int HALF = 32;
    localparam int MID  = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bclk_in;
    logic [NL-1:0] pdm_din;
    logic          cfg_we;
    logic [1:0]    cfg_addr;
    logic [31:0]   cfg_wdata;
    logic [31:0]   cfg_rdata;
    logic [NC-1:0] smp_bits;
    logic          smp_valid;

    int checks = 0;
    int fails  = 0;
    int nvalid = 0;
    bit done   = 1'b0;
    logic [NC-1:0] last_bits = '0;

    always #2.5 clk = ~clk;

    pdm_edge_sampler dut_i (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .pdm_din(pdm_din),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .smp_bits(smp_bits), .smp_valid(smp_valid)
    );

    always @(negedge clk) begin
        if (smp_valid) begin
            nvalid++;
            last_bits = smp_bits;
        end
    end

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NC-1:0] expand(logic [NL-1:0] hi, logic [NL-1:0] lo);
        logic [NC-1:0] e;
        for (int k = 0; k < NL; k++) begin
            e[2*k]   = hi[k];
            e[2*k+1] = lo[k];
        end
        return e;
    endfunction

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(logic [1:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check32(tag, cfg_rdata, exp);
    endtask

    task automatic run_period(logic [NL-1:0] a_hi, logic [NL-1:0] b_hi,
                              logic [NL-1:0] a_lo, logic [NL-1:0] b_lo);
        for (int j = 0; j < 2*HALF; j++) begin
            @(negedge clk);
            bclk_in = (j < HALF);
            if (j < HALF) pdm_din = (j < MID) ? a_hi : b_hi;
            else          pdm_din = (j - HALF < MID) ? a_lo : b_lo;
        end
    endtask

    // one period of zero data; strobes of the previous period counted in its first cycles
    task automatic check_window(int exp_cnt, logic [NC-1:0] exp_bits, string tag);
        int n0;
        n0 = nvalid;
        for (int j = 0; j < 2*HALF; j++) begin
            @(negedge clk);
            bclk_in = (j < HALF);
            pdm_din = '0;
            if (j == 10) begin
                check32({tag, " strobe count"}, 32'(nvalid - n0), 32'(exp_cnt));
                if (exp_cnt > 0) check32({tag, " bits"}, 32'(last_bits), 32'(exp_bits));
            end
        end
    endtask

    task automatic t_reset();
        rd_chk(2'd0, 32'h0000_0000, "R1 ctrl reset");
        rd_chk(2'd1, 32'h1818_1818, "R1 ptr word lo reset");
        rd_chk(2'd2, 32'h1818_1818, "R1 ptr word hi reset");
        check32("R1 smp_valid reset", 32'(smp_valid), 32'd0);
        check32("R1 smp_bits reset", 32'(smp_bits), 32'd0);
    endtask

    task automatic t_regs();
        wr(2'd0, 32'hFFFF_FFFF);
        rd_chk(2'd0, 32'h8000_FFFF, "R2 ctrl readback");
        wr(2'd0, 32'h0000_0000);
        wr(2'd1, 32'h0403_0201);
        rd_chk(2'd1, 32'h0403_0201, "R2 ptr lo readback");
        wr(2'd3, 32'hDEAD_BEEF);
        rd_chk(2'd3, 32'h0000_0000, "R2 unused address");
        rd_chk(2'd2, 32'h1818_1818, "R2 ptr hi untouched");
    endtask

    task automatic t_basic();
        wr(2'd1, 32'h0505_0505);
        wr(2'd2, 32'h0505_0505);
        wr(2'd0, 32'h8000_FFFF);
        run_period('0, '0, '0, '0);
        run_period(4'b1010, 4'b1010, 4'b0110, 4'b0110);
        check_window(1, expand(4'b1010, 4'b0110), "R3 pattern A");
        run_period(4'b0101, 4'b0101, 4'b1001, 4'b1001);
        check_window(1, expand(4'b0101, 4'b1001), "R3 pattern B");
        run_period(4'b1111, 4'b1111, 4'b0000, 4'b0000);
        check_window(1, 8'h55, "R8 one strobe per period");
    endtask

    task automatic t_offset();
        wr(2'd1, 32'h1818_0202);
        wr(2'd2, 32'h1414_1414);
        run_period('0, 4'hF, '0, 4'hF);
        check_window(1, 8'hFC, "R4 pointer offset");
    endtask

    task automatic t_beyond();
        wr(2'd2, 32'h1414_C814);
        run_period(4'hF, 4'hF, 4'hF, 4'hF);
        check_window(1, 8'hDF, "R5 pointer beyond half");
    endtask

    task automatic t_inactive();
        wr(2'd1, 32'h0505_0505);
        wr(2'd2, 32'h0505_0505);
        wr(2'd0, 32'h8000_0F3C);
        run_period(4'hF, 4'hF, 4'hF, 4'hF);
        check_window(1, 8'h0C, "R6 inactive channels zero");
    endtask

    task automatic t_disable();
        int n0;
        wr(2'd0, 32'h0000_FFFF);
        n0 = nvalid;
        run_period(4'hF, 4'hF, 4'hF, 4'hF);
        run_period(4'hF, 4'hF, 4'hF, 4'hF);
        check32("R7 no strobe while disabled", 32'(nvalid - n0), 32'd0);
        wr(2'd0, 32'h8000_FFFF);
        check_window(0, '0, "R7 first edge only aligns");
        run_period(4'hF, 4'hF, 4'hF, 4'hF);
        check_window(1, 8'hFF, "R7 strobe after alignment");
    endtask

    initial begin
        rst_n = 1'b0; bclk_in = 1'b0; pdm_din = '0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_regs();
        t_basic();
        t_offset();
        t_beyond();
        t_inactive();
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule